// File: doc/BRIEF.md
# Shift-Right Read-Modify-Write Execution Unit

This unit carries out the one-bit logical shift right for a small accumulator-based CPU core. The core hands it an already fetched opcode, up to two operand bytes, and copies of the X index, direct-page base, data-bank, accumulator and status registers. The unit works out the effective address and reads the operand through a byte-wide memory port. It shifts the operand right by one with a zero entering at the top, then writes the result back. It returns the updated status byte and accumulator, the cycle cost the instruction is charged, and the instruction length in bytes.

The operation width is picked per instruction by a mode input: 8 bits when it is high, 16 bits when it is low. In 16-bit mode a memory word spans two consecutive byte addresses and is read and written low byte first. The accumulator form needs no memory traffic and completes in a single cycle.

Top module: `srmw_unit`

## Requirements
- R1: A start is accepted only in idle and only for opcode 0x4A (accumulator), 0x4E (absolute), 0x5E (absolute plus X), 0x46 (direct page) or 0x56 (direct page plus X). Any other opcode is ignored: busy stays low, no memory access is made, and the outputs keep their values.
- R2: With `narrow` high the operation is 8 bits wide and touches one byte at the effective address. With it low the operation is 16 bits wide: the low byte is read at the effective address and the high byte at address+1, and the write-back uses the same byte order.
- R3: The value written back, or placed in the accumulator, equals the operand divided by two (integer) at the active width.
- R4: Status bit 0 (carry) receives bit 0 of the operand taken before the shift.
- R5: Status bit 1 (zero) is set exactly when the shifted result is zero at the active width. Status bit 7 (negative) is the result's top bit at the active width, so it is always 0.
- R6: For the 8-bit accumulator form, accumulator bits 15:8 come out unchanged. The memory forms return the accumulator unchanged.
- R7: The absolute address is {bank, hi, lo}. For the X form, the 16-bit value {hi, lo} plus X wraps modulo 2^16 before the bank byte is placed in bits 23:16.
- R8: The direct-page address is the 24-bit zero-extended sum of the direct-page register and the offset byte `oper_lo`, with X added for the indexed form. The sum may carry into bit 16.
- R9: The reported cycle cost is 2 for the accumulator form. For 8-bit / 16-bit memory operations it is: absolute 6/8, absolute plus X 7/9, direct page 5/7, direct page plus X 6/8.
- R10: The direct-page forms cost one more cycle whenever the low byte of the direct-page register is nonzero.
- R11: The reported instruction length is 1 byte for the accumulator form, 3 for the absolute forms and 2 for the direct-page forms.
- R12: Status bits 6 to 2 pass through from the status input unchanged.
- R13: `done` is a one-cycle pulse. It rises 1 cycle after acceptance for the accumulator form, 4 cycles after for 8-bit memory forms and 6 cycles after for 16-bit memory forms. Starts while busy are ignored and do not disturb the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute the presented opcode |
| opcode | input | 8 | Decoded opcode byte |
| oper_lo | input | 8 | First operand byte (low address byte or direct-page offset) |
| oper_hi | input | 8 | Second operand byte (high address byte, absolute forms) |
| idx_x | input | 16 | X index register |
| dpage | input | 16 | Direct-page base register |
| dbank | input | 8 | Data-bank register |
| acc_in | input | 16 | Accumulator before the instruction |
| stat_in | input | 8 | Status byte before the instruction |
| narrow | input | 1 | 1: 8-bit operation, 0: 16-bit operation |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after mem_rd |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 16 | Accumulator after the instruction |
| stat_out | output | 8 | Status byte after the instruction |
| cyc_cost | output | 4 | Cycles charged to the instruction |
| instr_len | output | 2 | Instruction length in bytes |

## Verification
The bench drives `start` on a falling edge and counts falling edges until `done` is seen. The count must be 1, 4 or 6 according to form and width. The status, accumulator, cost and length outputs are registered, so they are sampled on that same falling edge, when they are already final. Memory reads return data one cycle after the strobe, and writes land on the rising edge of the strobe cycle. The bench therefore checks the read and write address logs and the memory contents only after `done`. Ignored-start cases watch the ports for three further cycles before the next stimulus.

// File: rtl/srmw_pkg.sv
package srmw_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 4;
    localparam int LEN_W  = 2;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 7;

    typedef enum logic [2:0] {
        FORM_ACC,
        FORM_ABS,
        FORM_ABSX,
        FORM_DP,
        FORM_DPX
    } form_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_CAP,
        ST_WR_LO,
        ST_WR_HI,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic  ok;
        form_e form;
    } decode_t;

    function automatic decode_t decode_op(input logic [7:0] opc);
        decode_t d;
        d.ok   = 1'b1;
        d.form = FORM_ACC;
        case (opc)
            8'h4A:   d.form = FORM_ACC;
            8'h4E:   d.form = FORM_ABS;
            8'h5E:   d.form = FORM_ABSX;
            8'h46:   d.form = FORM_DP;
            8'h56:   d.form = FORM_DPX;
            default: d.ok   = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic is_dp(input form_e f);
        return (f == FORM_DP) || (f == FORM_DPX);
    endfunction

endpackage

// File: rtl/srmw_addr_gen.sv
module srmw_addr_gen
    import srmw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W
) (
    input  form_e         form,
    input  logic [BW-1:0] lo,
    input  logic [BW-1:0] hi,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] dp,
    input  logic [BW-1:0] bank,
    output logic [AW-1:0] ea
);
    logic [DW-1:0] abs_off;
    logic [DW-1:0] absx_off;
    logic [AW-1:0] dp_sum;

    always_comb begin
        abs_off  = DW'({hi, lo});
        absx_off = abs_off + x;
        dp_sum   = AW'(dp) + AW'(lo) + ((form == FORM_DPX) ? AW'(x) : '0);
        case (form)
            FORM_ABS:           ea = AW'({bank, abs_off});
            FORM_ABSX:          ea = AW'({bank, absx_off});
            FORM_DP, FORM_DPX:  ea = dp_sum;
            default:            ea = '0;
        endcase
    end
endmodule

// File: rtl/srmw_cost.sv
module srmw_cost
    import srmw_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LEN_W
) (
    input  form_e         form,
    input  logic          narrow,
    input  logic          dp_lo_nz,
    output logic [CW-1:0] cost,
    output logic [LW-1:0] len
);
    localparam logic [CW-1:0] WIDE_EXTRA = CW'(2);

    logic [CW-1:0] base;

    always_comb begin
        case (form)
            FORM_ABS:  begin base = CW'(6); len = LW'(3); end
            FORM_ABSX: begin base = CW'(7); len = LW'(3); end
            FORM_DP:   begin base = CW'(5); len = LW'(2); end
            FORM_DPX:  begin base = CW'(6); len = LW'(2); end
            default:   begin base = CW'(2); len = LW'(1); end
        endcase
        cost = base;
        if (form != FORM_ACC && !narrow)
            cost = cost + WIDE_EXTRA;
        if (is_dp(form) && dp_lo_nz)
            cost = cost + CW'(1);
    end
endmodule

// File: rtl/srmw_shift.sv
module srmw_shift
    import srmw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W
) (
    input  logic [DW-1:0] src,
    input  logic          narrow,
    input  logic [7:0]    stat_i,
    output logic [DW-1:0] res,
    output logic [7:0]    stat_o
);
    logic [BW-1:0] lane_lo;
    logic [DW-1:0] full;

    always_comb begin
        lane_lo = src[BW-1:0] >> 1;
        full    = src >> 1;
        res     = narrow ? {src[DW-1:BW], lane_lo} : full;
        stat_o        = stat_i;
        stat_o[FLG_C] = src[0];
        stat_o[FLG_Z] = narrow ? (res[BW-1:0] == '0) : (res == '0);
        stat_o[FLG_N] = narrow ? res[BW-1] : res[DW-1];
    end
endmodule

// File: rtl/srmw_unit.sv
module srmw_unit
    import srmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [BYTE_W-1:0] oper_lo,
    input  logic [BYTE_W-1:0] oper_hi,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] dpage,
    input  logic [BYTE_W-1:0] dbank,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [7:0]        stat_in,
    input  logic              narrow,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc_out,
    output logic [7:0]        stat_out,
    output logic [CNT_W-1:0]  cyc_cost,
    output logic [LEN_W-1:0]  instr_len
);
    localparam int HI_LSB = BYTE_W;

    state_e              state_q, state_d;
    form_e               form_q;
    logic                byte_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   opnd_q;
    logic [DATA_W-1:0]   acc_q;
    logic [7:0]          stat_q;
    logic [DATA_W-1:0]   acc_out_q;
    logic [7:0]          stat_out_q;
    logic [CNT_W-1:0]    cost_q;
    logic [LEN_W-1:0]    len_q;

    decode_t             dec;
    logic                accept;
    logic [ADDR_W-1:0]   ea;
    logic [CNT_W-1:0]    cost_d;
    logic [LEN_W-1:0]    len_d;
    logic [DATA_W-1:0]   sh_src;
    logic                sh_narrow;
    logic [7:0]          sh_stat_i;
    logic [DATA_W-1:0]   sh_res;
    logic [7:0]          sh_stat_o;
    logic                last_wr;

    assign dec    = decode_op(opcode);
    assign accept = start && (state_q == ST_IDLE) && dec.ok;

    srmw_addr_gen #(.AW(ADDR_W), .DW(DATA_W), .BW(BYTE_W)) addr_i (
        .form (dec.form),
        .lo   (oper_lo),
        .hi   (oper_hi),
        .x    (idx_x),
        .dp   (dpage),
        .bank (dbank),
        .ea   (ea)
    );

    srmw_cost #(.CW(CNT_W), .LW(LEN_W)) cost_i (
        .form     (dec.form),
        .narrow   (narrow),
        .dp_lo_nz (dpage[BYTE_W-1:0] != '0),
        .cost     (cost_d),
        .len      (len_d)
    );

    // The accumulator form shifts straight from the inputs in idle;
    // memory forms shift the captured operand.
    always_comb begin
        if (state_q == ST_IDLE) begin
            sh_src    = acc_in;
            sh_narrow = narrow;
            sh_stat_i = stat_in;
        end else begin
            sh_src    = opnd_q;
            sh_narrow = byte_q;
            sh_stat_i = stat_q;
        end
    end

    srmw_shift #(.DW(DATA_W), .BW(BYTE_W)) shift_i (
        .src    (sh_src),
        .narrow (sh_narrow),
        .stat_i (sh_stat_i),
        .res    (sh_res),
        .stat_o (sh_stat_o)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept) state_d = (dec.form == FORM_ACC) ? ST_FIN : ST_RD_LO;
            ST_RD_LO: state_d = byte_q ? ST_CAP : ST_RD_HI;
            ST_RD_HI: state_d = ST_CAP;
            ST_CAP:   state_d = ST_WR_LO;
            ST_WR_LO: state_d = byte_q ? ST_FIN : ST_WR_HI;
            ST_WR_HI: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign last_wr = ((state_q == ST_WR_LO) && byte_q) || (state_q == ST_WR_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            form_q     <= FORM_ACC;
            byte_q     <= 1'b0;
            addr_q     <= '0;
            opnd_q     <= '0;
            acc_q      <= '0;
            stat_q     <= '0;
            acc_out_q  <= '0;
            stat_out_q <= '0;
            cost_q     <= '0;
            len_q      <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                form_q <= dec.form;
                byte_q <= narrow;
                addr_q <= ea;
                acc_q  <= acc_in;
                stat_q <= stat_in;
                opnd_q <= '0;
                cost_q <= cost_d;
                len_q  <= len_d;
                if (dec.form == FORM_ACC) begin
                    acc_out_q  <= sh_res;
                    stat_out_q <= sh_stat_o;
                end
            end
            if (state_q == ST_RD_HI)
                opnd_q[BYTE_W-1:0] <= mem_rdata;
            if (state_q == ST_CAP) begin
                if (byte_q) opnd_q[BYTE_W-1:0]      <= mem_rdata;
                else        opnd_q[DATA_W-1:HI_LSB] <= mem_rdata;
            end
            if (last_wr) begin
                acc_out_q  <= acc_q;
                stat_out_q <= sh_stat_o;
            end
        end
    end

    always_comb begin
        mem_rd    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        mem_wr    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
        mem_addr  = ((state_q == ST_RD_HI) || (state_q == ST_WR_HI)) ? addr_q + ADDR_W'(1) : addr_q;
        mem_wdata = (state_q == ST_WR_HI) ? sh_res[DATA_W-1:HI_LSB] : sh_res[BYTE_W-1:0];
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign acc_out   = acc_out_q;
    assign stat_out  = stat_out_q;
    assign cyc_cost  = cost_q;
    assign instr_len = len_q;

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(addr_q)));

    // R5
    neg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !stat_out[FLG_N]);

    // R3
    byte_wr_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && byte_q) |-> !mem_wdata[BYTE_W-1]);

    // R9
    cost_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cyc_cost >= CNT_W'(2) && cyc_cost <= CNT_W'(9)));

    // R12
    stat_pass_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (stat_out[6:2] == stat_q[6:2]));

endmodule

// File: tb/srmw_unit_tb.sv
`timescale 1ns/1ps
module srmw_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  oper_lo = 8'h00;
    logic [7:0]  oper_hi = 8'h00;
    logic [15:0] idx_x = 16'h0;
    logic [15:0] dpage = 16'h0;
    logic [7:0]  dbank = 8'h0;
    logic [15:0] acc_in = 16'h0;
    logic [7:0]  stat_in = 8'h0;
    logic        narrow = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy, done;
    logic [15:0] acc_out;
    logic [7:0]  stat_out;
    logic [3:0]  cyc_cost;
    logic [1:0]  instr_len;

    int errors = 0;
    int checks = 0;

    logic [7:0]  mem [0:4095];
    logic [23:0] rd_log [0:3];
    logic [23:0] wr_log [0:3];
    int          rd_n = 0;
    int          wr_n = 0;

    always #2 clk = ~clk;

    srmw_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .oper_lo(oper_lo), .oper_hi(oper_hi), .idx_x(idx_x), .dpage(dpage),
        .dbank(dbank), .acc_in(acc_in), .stat_in(stat_in), .narrow(narrow),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .acc_out(acc_out), .stat_out(stat_out), .cyc_cost(cyc_cost),
        .instr_len(instr_len)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[11:0]];
            rd_log[rd_n % 4] <= mem_addr;
            rd_n <= rd_n + 1;
        end
        if (mem_wr) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            wr_log[wr_n % 4] <= mem_addr;
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [15:0] x, input logic [15:0] dp, input logic [7:0] db,
                          input logic [15:0] acc, input logic [7:0] fl, input logic bm,
                          input logic [15:0] data, input logic poke);
        logic [23:0] ea;
        logic [15:0] opnd, res, exp_acc;
        logic [7:0]  exp_fl;
        int          exp_cost, exp_len, exp_lat, lat, rb, wb;
        logic        is_mem, dpf;
        is_mem = (opc != 8'h4A);
        dpf    = (opc == 8'h46) || (opc == 8'h56);
        case (opc)
            8'h4E: ea = {db, hi, lo};
            8'h5E: ea = {db, 16'({hi, lo} + x)};
            8'h46: ea = 24'(dp) + 24'(lo);
            8'h56: ea = 24'(dp) + 24'(lo) + 24'(x);
            default: ea = 24'h0;
        endcase
        case (opc)
            8'h4E: begin exp_cost = bm ? 6 : 8; exp_len = 3; end
            8'h5E: begin exp_cost = bm ? 7 : 9; exp_len = 3; end
            8'h46: begin exp_cost = bm ? 5 : 7; exp_len = 2; end
            8'h56: begin exp_cost = bm ? 6 : 8; exp_len = 2; end
            default: begin exp_cost = 2; exp_len = 1; end
        endcase
        if (dpf && dp[7:0] != 8'h00) exp_cost = exp_cost + 1;
        exp_lat = !is_mem ? 1 : (bm ? 4 : 6);
        if (is_mem) opnd = bm ? {8'h00, data[7:0]} : data;
        else        opnd = acc;
        if (bm) res = {(is_mem ? 8'h00 : opnd[15:8]), 8'(opnd[7:0] / 2)};
        else    res = opnd / 2;
        exp_acc   = is_mem ? acc : res;
        exp_fl    = fl;
        exp_fl[0] = opnd[0];
        exp_fl[1] = bm ? (res[7:0] == 8'h00) : (res == 16'h0000);
        exp_fl[7] = bm ? res[7] : res[15];
        if (is_mem) begin
            mem[ea[11:0]] = data[7:0];
            if (!bm) mem[12'(ea + 24'd1)] = data[15:8];
        end
        rb = rd_n; wb = wr_n;
        opcode = opc; oper_lo = lo; oper_hi = hi; idx_x = x; dpage = dp;
        dbank = db; acc_in = acc; stat_in = fl; narrow = bm; start = 1'b1;
        lat = 0;
        while (lat < 20) begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                start = 1'b0;
                if (poke) begin
                    start = 1'b1; opcode = 8'h4A; acc_in = 16'hFFFF; stat_in = 8'hFF;
                end
            end
            if (lat == 2 && poke) begin
                start = 1'b0; opcode = opc; acc_in = acc; stat_in = fl;
            end
            if (done) break;
        end
        start = 1'b0;
        chk("R13 done latency", lat, exp_lat);
        chk("R3 R6 accumulator result", acc_out, exp_acc);
        chk("R4 carry", stat_out[0], exp_fl[0]);
        chk("R5 zero and negative", {stat_out[7], stat_out[1]}, {exp_fl[7], exp_fl[1]});
        chk("R12 untouched status bits", stat_out[6:2], exp_fl[6:2]);
        chk(dpf ? "R10 cycle cost" : "R9 cycle cost", cyc_cost, exp_cost);
        chk("R11 instruction length", instr_len, exp_len);
        @(negedge clk);
        chk("R13 done one cycle", done, 1'b0);
        if (is_mem) begin
            chk("R2 read count", rd_n - rb, bm ? 1 : 2);
            chk("R2 write count", wr_n - wb, bm ? 1 : 2);
            chk(dpf ? "R8 read address" : "R7 read address", rd_log[rb % 4], ea);
            chk("R2 write address", wr_log[wb % 4], ea);
            chk("R3 written low byte", mem[ea[11:0]], res[7:0]);
            if (!bm) begin
                chk("R2 high read address", rd_log[(rb + 1) % 4], ea + 24'd1);
                chk("R2 high write address", wr_log[(wb + 1) % 4], ea + 24'd1);
                chk("R3 written high byte", mem[12'(ea + 24'd1)], res[15:8]);
            end
        end else begin
            chk("R1 no memory access for accumulator form", (rd_n - rb) + (wr_n - wb), 0);
        end
    endtask

    function automatic logic [15:0] pattern(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h8000;
            3: return 16'hFFFF;
            4: return 16'h0100;
            5: return 16'h00FF;
            6: return 16'h1234;
            default: return 16'hA5A5;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] ops [0:3];
        logic [15:0] prev_acc;
        logic [7:0]  prev_stat;
        int          rb;
        ops[0] = 8'h4E; ops[1] = 8'h5E; ops[2] = 8'h46; ops[3] = 8'h56;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 reset busy", busy, 1'b0);
        chk("R13 reset done", done, 1'b0);
        chk("R12 reset status", stat_out, 8'h00);
        chk("R6 reset accumulator", acc_out, 16'h0000);
        chk("R9 reset cost", cyc_cost, 4'h0);

        // R6 R3: 8-bit accumulator sweep
        for (int v = 0; v < 256; v++)
            run_op(8'h4A, 8'h00, 8'h00, 16'(v * 3), 16'h0000, 8'h00,
                   {8'(v * 7 + 3), 8'(v)}, 8'(v) ^ 8'h6C, 1'b1, 16'h0000, 1'b0);
        // R3 R5: 16-bit accumulator sweep
        for (int v = 0; v < 256; v++)
            run_op(8'h4A, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h00,
                   16'(v * 259) ^ ((v % 2 == 1) ? 16'h8000 : 16'h0000),
                   8'(v * 5), 1'b0, 16'h0000, 1'b0);
        run_op(8'h4A, 8'h00, 8'h00, 16'h0, 16'h0, 8'h0, 16'hFFFF, 8'h00, 1'b0, 16'h0, 1'b0);
        run_op(8'h4A, 8'h00, 8'h00, 16'h0, 16'h0, 8'h0, 16'h0001, 8'hFF, 1'b0, 16'h0, 1'b0);

        // R7 R8 R9 R10 R2: memory forms, both widths, both direct-page alignments
        for (int o = 0; o < 4; o++)
            for (int w = 0; w < 2; w++)
                for (int a = 0; a < 2; a++)
                    for (int k = 0; k < 8; k++)
                        run_op(ops[o], 8'(8'h20 + k * 8), 8'h02, 16'h0031,
                               (a == 1) ? 16'h0345 : 16'h0300, 8'(8'h3C + k),
                               16'hBEEF, 8'h40 | 8'(k), (w == 1), pattern(k), (k == 3));

        // R7: indexed absolute wraps within the bank
        run_op(8'h5E, 8'hF8, 8'hFF, 16'h0010, 16'h0000, 8'h12, 16'h1111, 8'h3C, 1'b0, 16'h0003, 1'b0);
        // R8: direct-page sum carries into bit 16
        run_op(8'h56, 8'h20, 8'h00, 16'h0005, 16'hFFF0, 8'h77, 16'h2222, 8'h00, 1'b1, 16'h0042, 1'b0);
        run_op(8'h46, 8'h20, 8'h00, 16'h0000, 16'hFFF0, 8'h77, 16'h2222, 8'h00, 1'b0, 16'h4003, 1'b0);

        // R1: unsupported opcode is ignored
        prev_acc = acc_out; prev_stat = stat_out; rb = rd_n;
        opcode = 8'hEA; acc_in = 16'h5555; stat_in = 8'hAA; narrow = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk("R1 ignored opcode busy", busy, 1'b0);
            @(negedge clk);
        end
        chk("R1 ignored opcode no read", rd_n - rb, 0);
        chk("R1 ignored opcode accumulator", acc_out, prev_acc);
        chk("R1 ignored opcode status", stat_out, prev_stat);

        summary();
        $finish;
    end
endmodule